// File: doc/BRIEF.md
# Delayed Transaction Target Buffer

This block is the target side of a parallel bus. It serves accesses that take too long to finish inside the bus timing budget. When a memory read or write arrives and the buffer slot is empty, the block records the whole request and answers with a retry. It then runs the access on a request/acknowledge backend port while the initiator is away. When the initiator repeats exactly the same request after the backend has answered, the block completes it from the stored result and frees the slot.

The slot holds one request. While it is occupied, every other claimed request is answered with a retry and is not recorded. A matching repeat that arrives before the backend has answered also gets a retry. The block does not track which initiator made a request, so any initiator that issues an identical request receives the stored completion. If no matching repeat arrives within a configurable number of clocks after the backend completes, the slot is dropped.

The bus is simplified to one data phase per request. A request is a single cycle in which `busFrame` and `busIrdy` are both high. In that same cycle the command, address, byte enables and write data are valid. The block answers in the following cycle.

Top module: `dly_txn_target`

## Requirements
- R1: While reset is applied and just after it ends, `busDevsel`, `busStop`, `busTrdy`, `busRdata` and `bkReq` are all low.
- R2: A cycle with `busFrame` and `busIrdy` high but a command other than 4'h6 (memory read) or 4'h7 (memory write) gets no response in the following cycle. No response means `busDevsel`, `busStop` and `busTrdy` all low. Such a cycle records nothing and starts no backend access.
- R3: A supported request that arrives while the slot is empty is recorded. In the next cycle it is answered with `busDevsel` and `busStop` high and `busTrdy` low. Command bit 0 set means a write.
- R4: In the cycle after recording, `bkReq` goes high with `bkWrite`, `bkAddr`, `bkBe` and `bkWdata` equal to the recorded request. These stay stable until the cycle in which `bkAck` is high, and `bkReq` drops in the next cycle. `bkRdata` is stored on that acknowledge.
- R5: A request that matches the recorded one is answered with a retry (`busStop` high, `busTrdy` low) while the backend access is still in progress.
- R6: A supported request that does not match is answered with a retry while the slot is occupied. It is not recorded and starts no backend access.
- R7: Once the backend has acknowledged, a matching request is answered with `busDevsel` and `busTrdy` high and `busStop` low. For a read, `busRdata` carries the stored backend data in that cycle; for a write it is zero.
- R8: A match requires equal command, address and byte enables, and for writes equal write data. A repeat that differs in byte enables or in write data gets a retry.
- R9: Delivering a completion frees the slot. The next identical request is treated as new: it gets a retry and starts a new backend access.
- R10: A completed slot with no matching request for DISCARD_CYCLES clocks after the acknowledge is freed. A later identical request then starts a new backend access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busFrame | input | 1 | Initiator frames a request |
| busIrdy | input | 1 | Initiator ready; a request is taken when both this and busFrame are high |
| busCmd | input | 4 | Command code (4'h6 read, 4'h7 write) |
| busAddr | input | AW | Request address |
| busBe | input | DW/8 | Byte enables, active high |
| busWdata | input | DW | Write data |
| busDevsel | output | 1 | Target claims the request |
| busStop | output | 1 | Retry: the request is not completed |
| busTrdy | output | 1 | Request completed in this cycle |
| busRdata | output | DW | Read data that goes with busTrdy |
| bkReq | output | 1 | Backend access request, held until bkAck |
| bkWrite | output | 1 | Backend access is a write |
| bkAddr | output | AW | Backend address |
| bkBe | output | DW/8 | Backend byte enables |
| bkWdata | output | DW | Backend write data |
| bkAck | input | 1 | Backend completion, one cycle |
| bkRdata | input | DW | Backend read data, valid with bkAck |

## Verification
Each bus response is registered, so it appears exactly one cycle after the cycle in which the request is sampled. The driver places a request at a falling edge, and the response monitor compares it 2 ns after the next rising edge against the entry the driver queued. The backend request rises one cycle after the recording edge; the backend model checks its fields at the first falling edge where `bkReq` is high. Repeats are timed by cycle count against the model's acknowledge latency, so that each one lands either before or after the acknowledge edge as the test intends.

// File: rtl/dly_txn_pkg.sv
`timescale 1ns/1ps
package dly_txn_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;

  typedef enum logic [1:0] {
    SLOT_EMPTY,
    SLOT_BUSY,
    SLOT_DONE
  } slotState_t;

  typedef struct packed {
    logic capture;     // record the request into the slot
    logic storeRdata;  // keep backend read data
    logic respClaim;   // drive devsel next cycle
    logic respStop;    // answer with retry
    logic respTrdy;    // answer with completion
  } ctrlStrobe_t;

endpackage

// File: rtl/dly_txn_ctrl.sv
`timescale 1ns/1ps
module dly_txn_ctrl
  import dly_txn_pkg::*;
#(
  parameter int DISCARD_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqHit,
  input  logic        reqMatch,
  input  logic        bkAck,
  output ctrlStrobe_t strobe,
  output logic        bkReq
);

  localparam int CNT_W = $clog2(DISCARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DISCARD_CYCLES - 1);

  slotState_t state, stateNext;
  logic [CNT_W-1:0] discardCnt;

  always_comb begin
    strobe = '0;
    strobe.storeRdata = (state == SLOT_BUSY) && bkAck;
    if (reqHit) begin
      strobe.respClaim = 1'b1;
      unique case (state)
        SLOT_EMPTY: begin
          strobe.capture  = 1'b1;
          strobe.respStop = 1'b1;
        end
        SLOT_BUSY: strobe.respStop = 1'b1;
        SLOT_DONE: begin
          strobe.respTrdy = reqMatch;
          strobe.respStop = !reqMatch;
        end
        default: strobe.respStop = 1'b1;
      endcase
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      SLOT_EMPTY: if (reqHit) stateNext = SLOT_BUSY;
      SLOT_BUSY:  if (bkAck) stateNext = SLOT_DONE;
      SLOT_DONE: begin
        if (reqHit && reqMatch) stateNext = SLOT_EMPTY;
        else if (discardCnt == CNT_LAST) stateNext = SLOT_EMPTY;
      end
      default: stateNext = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SLOT_EMPTY;
      discardCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == SLOT_DONE) discardCnt <= discardCnt + 1'b1;
      else                    discardCnt <= '0;
    end
  end

  assign bkReq = (state == SLOT_BUSY);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bkReq && !bkAck |=> bkReq); // R4
  AST_CAPTURE_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> bkReq); // R3
  AST_DELIVER_FREES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respTrdy |=> state == SLOT_EMPTY); // R9
  AST_DISCARD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == SLOT_DONE |-> discardCnt < CNT_W'(DISCARD_CYCLES)); // R10

endmodule

// File: rtl/dly_txn_dpath.sv
`timescale 1ns/1ps
module dly_txn_dpath
  import dly_txn_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busFrame,
  input  logic            busIrdy,
  input  logic [3:0]      busCmd,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW/8-1:0] busBe,
  input  logic [DW-1:0]   busWdata,
  input  ctrlStrobe_t     strobe,
  input  logic [DW-1:0]   bkRdata,
  output logic            reqHit,
  output logic            reqMatch,
  output logic            busDevsel,
  output logic            busStop,
  output logic            busTrdy,
  output logic [DW-1:0]   busRdata,
  output logic            bkWrite,
  output logic [AW-1:0]   bkAddr,
  output logic [DW/8-1:0] bkBe,
  output logic [DW-1:0]   bkWdata
);

  logic [3:0]      entryCmd;
  logic [AW-1:0]   entryAddr;
  logic [DW/8-1:0] entryBe;
  logic [DW-1:0]   entryWdata;
  logic [DW-1:0]   rdStore;
  logic            entryWrite;

  assign entryWrite = entryCmd[0];
  assign reqHit = busFrame && busIrdy &&
                  (busCmd == CMD_MEM_RD || busCmd == CMD_MEM_WR);
  assign reqMatch = (busCmd == entryCmd) && (busAddr == entryAddr) &&
                    (busBe == entryBe) &&
                    (!entryWrite || busWdata == entryWdata);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryCmd   <= '0;
      entryAddr  <= '0;
      entryBe    <= '0;
      entryWdata <= '0;
      rdStore    <= '0;
    end else begin
      if (strobe.capture) begin
        entryCmd   <= busCmd;
        entryAddr  <= busAddr;
        entryBe    <= busBe;
        entryWdata <= busCmd[0] ? busWdata : '0;
      end
      if (strobe.storeRdata) rdStore <= entryWrite ? '0 : bkRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busDevsel <= 1'b0;
      busStop   <= 1'b0;
      busTrdy   <= 1'b0;
      busRdata  <= '0;
    end else begin
      busDevsel <= strobe.respClaim;
      busStop   <= strobe.respStop;
      busTrdy   <= strobe.respTrdy;
      busRdata  <= strobe.respTrdy ? rdStore : '0;
    end
  end

  assign bkWrite = entryWrite;
  assign bkAddr  = entryAddr;
  assign bkBe    = entryBe;
  assign bkWdata = entryWdata;

  AST_TRDY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    busTrdy |-> busDevsel && !busStop); // R7
  AST_STOP_CLAIMED: assert property (@(posedge clk) disable iff (!rstN)
    busStop |-> busDevsel); // R3

endmodule

// File: rtl/dly_txn_target.sv
`timescale 1ns/1ps
module dly_txn_target
  import dly_txn_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DISCARD_CYCLES = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busFrame,
  input  logic            busIrdy,
  input  logic [3:0]      busCmd,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW/8-1:0] busBe,
  input  logic [DW-1:0]   busWdata,
  output logic            busDevsel,
  output logic            busStop,
  output logic            busTrdy,
  output logic [DW-1:0]   busRdata,
  output logic            bkReq,
  output logic            bkWrite,
  output logic [AW-1:0]   bkAddr,
  output logic [DW/8-1:0] bkBe,
  output logic [DW-1:0]   bkWdata,
  input  logic            bkAck,
  input  logic [DW-1:0]   bkRdata
);

  ctrlStrobe_t strobe;
  logic reqHit, reqMatch;

  dly_txn_ctrl #(.DISCARD_CYCLES(DISCARD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqHit(reqHit), .reqMatch(reqMatch),
    .bkAck(bkAck), .strobe(strobe), .bkReq(bkReq)
  );

  dly_txn_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .busFrame(busFrame), .busIrdy(busIrdy),
    .busCmd(busCmd), .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .strobe(strobe), .bkRdata(bkRdata), .reqHit(reqHit), .reqMatch(reqMatch),
    .busDevsel(busDevsel), .busStop(busStop), .busTrdy(busTrdy),
    .busRdata(busRdata), .bkWrite(bkWrite), .bkAddr(bkAddr), .bkBe(bkBe),
    .bkWdata(bkWdata)
  );

  AST_BK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    bkReq && !bkAck |=> $stable(bkAddr) && $stable(bkWrite) && $stable(bkBe) && $stable(bkWdata)); // R4
  AST_BK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    bkReq && bkAck |=> !bkReq); // R4

endmodule

// File: tb/dly_txn_target_bench.sv
`timescale 1ns/1ps
module dly_txn_target_bench;

  localparam int DISCARD = 16;
  localparam int LAT = 4;
  localparam logic [2:0] RSP_NONE = 3'b000; // {devsel, stop, trdy}
  localparam logic [2:0] RSP_STOP = 3'b110;
  localparam logic [2:0] RSP_TRDY = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        busFrame = 0, busIrdy = 0;
  logic [3:0]  busCmd = 0;
  logic [31:0] busAddr = 0, busWdata = 0;
  logic [3:0]  busBe = 0;
  logic        busDevsel, busStop, busTrdy;
  logic [31:0] busRdata;
  logic        bkReq, bkWrite;
  logic [31:0] bkAddr, bkWdata;
  logic [3:0]  bkBe;
  logic        bkAck = 0;
  logic [31:0] bkRdata = 0;

  int checks = 0;
  int errors = 0;
  bit respDue = 0;
  bit finished = 0;
  int bkCnt = 0;

  logic [2:0]  expFlagQ[$];
  logic [31:0] expRdQ[$];
  string       respTagQ[$];
  logic [68:0] expBkQ[$];   // {write, addr, be, wdata}
  string       bkTagQ[$];

  dly_txn_target #(.AW(32), .DW(32), .DISCARD_CYCLES(DISCARD)) u_dly_txn_target (
    .clk(clk), .rstN(rstN), .busFrame(busFrame), .busIrdy(busIrdy),
    .busCmd(busCmd), .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busDevsel(busDevsel), .busStop(busStop), .busTrdy(busTrdy),
    .busRdata(busRdata), .bkReq(bkReq), .bkWrite(bkWrite), .bkAddr(bkAddr),
    .bkBe(bkBe), .bkWdata(bkWdata), .bkAck(bkAck), .bkRdata(bkRdata)
  );

  function automatic logic [31:0] bkData(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one request cycle, expected response queued
  task automatic busReq(input logic [3:0] cmd, input logic [31:0] addr,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic [2:0] expFlags, input logic [31:0] expRd,
                        input bit expBk, input string tag);
    @(negedge clk);
    expFlagQ.push_back(expFlags);
    expRdQ.push_back(expRd);
    respTagQ.push_back(tag);
    if (expBk) begin
      expBkQ.push_back({cmd[0], addr, be, cmd[0] ? wd : 32'h0});
      bkTagQ.push_back(tag);
    end
    busFrame = 1; busIrdy = 1; busCmd = cmd; busAddr = addr; busBe = be; busWdata = wd;
    respDue = 1;
    @(negedge clk);
    busFrame = 0; busIrdy = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // response monitor: response is due one cycle after the sampled request
  initial forever begin
    @(posedge clk);
    #2;
    if (respDue) begin
      logic [2:0] ef;
      logic [31:0] er;
      string t;
      respDue = 0;
      ef = expFlagQ.pop_front();
      er = expRdQ.pop_front();
      t  = respTagQ.pop_front();
      check({busDevsel, busStop, busTrdy} == ef, t, "devsel/stop/trdy",
            69'({busDevsel, busStop, busTrdy}), 69'(ef));
      check(busRdata == er, t, "rdata", 69'(busRdata), 69'(er));
    end
  end

  // backend model: checks request fields, acknowledges after LAT cycles
  initial forever begin
    @(negedge clk);
    if (bkAck) begin
      bkAck = 0;
      bkCnt = 0;
    end else if (bkReq) begin
      if (bkCnt == 0) begin
        if (expBkQ.size() == 0) begin
          check(0, "R6", "unexpected backend request", 69'(bkAddr), 69'(0));
        end else begin
          logic [68:0] e;
          string t;
          e = expBkQ.pop_front();
          t = bkTagQ.pop_front();
          check({bkWrite, bkAddr, bkBe, bkWdata} == e, t, "R4 backend fields",
                {bkWrite, bkAddr, bkBe, bkWdata}, e);
        end
      end
      bkCnt++;
      if (bkCnt == LAT) begin
        bkAck = 1;
        bkRdata = bkData(bkAddr);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check({busDevsel, busStop, busTrdy, bkReq} == 4'b0, "R1", "outputs in reset",
          69'({busDevsel, busStop, busTrdy, bkReq}), 69'(0));
    rstN = 1;
    idle(2);
    check({busDevsel, busStop, busTrdy, bkReq} == 4'b0 && busRdata == 0, "R1",
          "outputs after reset", 69'({busDevsel, busStop, busTrdy, bkReq}), 69'(0));

    // R2: unsupported command is not claimed and not recorded
    busReq(4'h2, 32'h0000_0050, 4'hF, 32'h0, RSP_NONE, 32'h0, 0, "R2");
    idle(8);

    // R3, R4: new read captured, retried, backend issued
    busReq(4'h6, 32'h0000_0100, 4'hF, 32'h0, RSP_STOP, 32'h0, 1, "R3");
    // R5: matching repeat while backend still busy
    busReq(4'h6, 32'h0000_0100, 4'hF, 32'h0, RSP_STOP, 32'h0, 0, "R5");
    // R6: other request while occupied: retried, not recorded
    busReq(4'h6, 32'h0000_0200, 4'hF, 32'h0, RSP_STOP, 32'h0, 0, "R6");
    idle(6);
    // R8: differing byte enables is not a match
    busReq(4'h6, 32'h0000_0100, 4'h3, 32'h0, RSP_STOP, 32'h0, 0, "R8");
    // R7: matching read delivers stored data
    busReq(4'h6, 32'h0000_0100, 4'hF, 32'h0, RSP_TRDY, bkData(32'h100), 0, "R7");
    // R9: slot freed, identical request starts again
    busReq(4'h6, 32'h0000_0100, 4'hF, 32'h0, RSP_STOP, 32'h0, 1, "R9");
    idle(8);
    busReq(4'h6, 32'h0000_0100, 4'hF, 32'h0, RSP_TRDY, bkData(32'h100), 0, "R9");

    // R6: earlier rejected request was not recorded, now new
    busReq(4'h6, 32'h0000_0200, 4'hF, 32'h0, RSP_STOP, 32'h0, 1, "R6");
    idle(8);
    busReq(4'h6, 32'h0000_0200, 4'hF, 32'h0, RSP_TRDY, bkData(32'h200), 0, "R6");

    // write path: R3, R8 (data mismatch), R7
    busReq(4'h7, 32'h0000_0300, 4'hC, 32'hDEAD_BEEF, RSP_STOP, 32'h0, 1, "R3");
    idle(8);
    busReq(4'h7, 32'h0000_0300, 4'hC, 32'h1234_5678, RSP_STOP, 32'h0, 0, "R8");
    busReq(4'h6, 32'h0000_0300, 4'hC, 32'h0, RSP_STOP, 32'h0, 0, "R8");
    busReq(4'h7, 32'h0000_0300, 4'hC, 32'hDEAD_BEEF, RSP_TRDY, 32'h0, 0, "R7");

    // R10: completed slot dropped after the discard window
    busReq(4'h6, 32'h0000_0400, 4'h1, 32'h0, RSP_STOP, 32'h0, 1, "R10");
    idle(DISCARD + LAT + 6);
    busReq(4'h6, 32'h0000_0400, 4'h1, 32'h0, RSP_STOP, 32'h0, 1, "R10");
    idle(8);
    busReq(4'h6, 32'h0000_0400, 4'h1, 32'h0, RSP_TRDY, bkData(32'h400), 0, "R10");

    idle(10);
    check(expBkQ.size() == 0, "R4", "backend requests outstanding",
          69'(expBkQ.size()), 69'(0));
    check(expFlagQ.size() == 0, "R3", "responses outstanding",
          69'(expFlagQ.size()), 69'(0));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule